// File: doc/BRIEF.md
# Serial Transceiver Reset Sequencer

This controller brings a serial transceiver channel out of reset after power-up, with the receiver in manual clock-recovery lock mode. It holds the PLL in analog reset for at least one microsecond, waits for the PLL to report lock, and then releases the transmit digital reset. It waits for the reconfiguration busy flag to go low and for two enabled parallel-clock cycles, and then lets the receive analog section run.

The clock-recovery unit first tracks the reference clock. After a programmable interval the controller switches it to track the incoming data. After a second interval it releases the receive digital reset and raises a ready flag. If the PLL loses lock at any point after the transmitter has been released, the whole sequence starts again from the beginning.

All waits are parameters counted in cycles of the free-running clock. The PLL reset length is derived from the clock frequency in MHz.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `por_n` is low, the outputs are forced at once, without waiting for a clock edge, to: `pll_rst`, `tx_drst`, `rx_arst`, `rx_drst` and `lock_ref` at 1, and `lock_dat` and `ready` at 0.
- R2: After `por_n` rises, `pll_rst` stays at 1 for exactly CLK_MHZ*PLL_US clock cycles. During that time `tx_drst`, `rx_arst`, `rx_drst` and `lock_ref` stay at 1, `lock_dat` stays at 0, and `pll_lock` has no effect.
- R3: After `pll_rst` is released, `tx_drst` falls on the first clock edge that samples `pll_lock` high. If `pll_lock` is already high, that is one cycle after `pll_rst` falls.
- R4: After `tx_drst` is released, `rx_arst` falls on the second enabled clock edge after the first edge that samples `busy` low. An edge counts as enabled only when `pclk_en` is 1. Pulses of `pclk_en` while `busy` is high, and cycles with `pclk_en` at 0, are not counted.
- R5: Exactly LTR_CYC cycles after `rx_arst` falls, `lock_ref` falls and `lock_dat` rises on the same edge.
- R6: Exactly LTD_CYC cycles after `lock_dat` rises, `rx_drst` falls.
- R7: `ready` rises on the same edge as `rx_drst` falls, and stays high while the PLL remains locked.
- R8: If `pll_lock` is sampled low while `tx_drst` is 0, the next edge returns every output to its R1 value. The sequence then restarts, with a full PLL reset interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pll_lock | input | 1 | PLL lock indication |
| busy | input | 1 | Reconfiguration busy flag |
| pclk_en | input | 1 | Enable marking one parallel-clock cycle |
| pll_rst | output | 1 | PLL analog reset |
| tx_drst | output | 1 | Transmit digital reset |
| rx_arst | output | 1 | Receive analog reset |
| rx_drst | output | 1 | Receive digital reset |
| lock_ref | output | 1 | Clock recovery tracks the reference clock |
| lock_dat | output | 1 | Clock recovery tracks the received data |
| ready | output | 1 | Channel ready for traffic |

## Verification
The bench measures each timed interval exactly at its edge. An off-by-one counter would move `pll_rst`, `lock_dat` or `rx_drst` one cycle early or late.

It sends `pclk_en` pulses while `busy` is still high, and leaves gaps in `pclk_en` after `busy` falls. A design that ignored the enable, or that counted before busy dropped, would release `rx_arst` too early.

It holds `pll_lock` high through the PLL reset to confirm that the transmitter waits for that reset to end. It also drops lock once the channel is ready, to confirm a full restart. A design that only cleared `ready`, or that skipped the microsecond PLL hold on restart, would fail these checks.

An asynchronous reset applied between clock edges must show the idle state before the next edge.

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int CLK_MHZ = 250,
  parameter int PLL_US  = 1,
  parameter int LTR_CYC = 5000,
  parameter int LTD_CYC = 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic pll_lock,
  input  logic busy,
  input  logic pclk_en,
  output logic pll_rst,
  output logic tx_drst,
  output logic rx_arst,
  output logic rx_drst,
  output logic lock_ref,
  output logic lock_dat,
  output logic ready
);
  localparam int PLL_CYC = CLK_MHZ * PLL_US;
  localparam int MAXC    = (PLL_CYC > LTR_CYC) ? ((PLL_CYC > LTD_CYC) ? PLL_CYC : LTD_CYC)
                                              : ((LTR_CYC > LTD_CYC) ? LTR_CYC : LTD_CYC);
  localparam int CW      = $clog2(MAXC + 1) + 1;

  localparam int B_PLL = 6, B_TX = 5, B_RXA = 4, B_RXD = 3, B_REF = 2, B_DAT = 1, B_RDY = 0;
  localparam logic [6:0] CTL_IDLE = 7'b1111100;

  typedef enum logic [2:0] {S_PLL, S_LOCK, S_BUSY, S_PCLK, S_LTR, S_LTD, S_RDY} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [6:0]     ctl;
  logic           lost;

  assign lost = (st inside {S_BUSY, S_PCLK, S_LTR, S_LTD, S_RDY}) && !pll_lock;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st  <= S_PLL;
      cnt <= '0;
      ctl <= CTL_IDLE;
    end else if (lost) begin
      st  <= S_PLL;
      cnt <= '0;
      ctl <= CTL_IDLE;
    end else begin
      case (st)
        S_PLL:
          if (cnt == CW'(PLL_CYC - 1)) begin
            st         <= S_LOCK;
            cnt        <= '0;
            ctl[B_PLL] <= 1'b0;
          end else cnt <= cnt + 1'b1;
        S_LOCK:
          if (pll_lock) begin
            st        <= S_BUSY;
            ctl[B_TX] <= 1'b0;
          end
        S_BUSY:
          if (!busy) begin
            st  <= S_PCLK;
            cnt <= '0;
          end
        S_PCLK:
          if (pclk_en) begin
            if (cnt == CW'(1)) begin
              st         <= S_LTR;
              cnt        <= '0;
              ctl[B_RXA] <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
        S_LTR:
          if (cnt == CW'(LTR_CYC - 1)) begin
            st         <= S_LTD;
            cnt        <= '0;
            ctl[B_REF] <= 1'b0;
            ctl[B_DAT] <= 1'b1;
          end else cnt <= cnt + 1'b1;
        S_LTD:
          if (cnt == CW'(LTD_CYC - 1)) begin
            st         <= S_RDY;
            cnt        <= '0;
            ctl[B_RXD] <= 1'b0;
            ctl[B_RDY] <= 1'b1;
          end else cnt <= cnt + 1'b1;
        default: ;
      endcase
    end
  end

  assign pll_rst  = ctl[B_PLL];
  assign tx_drst  = ctl[B_TX];
  assign rx_arst  = ctl[B_RXA];
  assign rx_drst  = ctl[B_RXD];
  assign lock_ref = ctl[B_REF];
  assign lock_dat = ctl[B_DAT];
  assign ready    = ctl[B_RDY];

  p_pll_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
    pll_rst |-> (tx_drst && rx_arst && rx_drst && lock_ref && !lock_dat));

  p_tx_needs_lock_r3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(tx_drst) |-> $past(pll_lock) && !pll_rst);

  p_arst_order_r4: assert property (@(posedge clk) disable iff (!por_n)
    !rx_arst |-> !tx_drst);

  p_mode_excl_r5: assert property (@(posedge clk) disable iff (!por_n)
    $onehot({lock_ref, lock_dat}));

  p_drst_after_ltd_r6: assert property (@(posedge clk) disable iff (!por_n)
    !rx_drst |-> (lock_dat && !rx_arst));

  p_ready_with_drst_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready) |-> $fell(rx_drst));

  p_restart_r8: assert property (@(posedge clk) disable iff (!por_n)
    (!tx_drst && !pll_lock) |=> (pll_rst && tx_drst && !ready));
endmodule

// File: tb/sim_xcvr_rst_seq.sv
module sim_xcvr_rst_seq;
  localparam int MHZ = 250;
  localparam int PUS = 1;
  localparam int LTR = 30;
  localparam int LTD = 17;
  localparam int PLLN = MHZ * PUS;

  logic clk = 0, por_n = 0, pll_lock = 0, busy = 1, pclk_en = 0;
  logic pll_rst, tx_drst, rx_arst, rx_drst, lock_ref, lock_dat, ready;
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  xcvr_rst_seq #(.CLK_MHZ(MHZ), .PLL_US(PUS), .LTR_CYC(LTR), .LTD_CYC(LTD)) u0 (
    .clk(clk), .por_n(por_n), .pll_lock(pll_lock), .busy(busy), .pclk_en(pclk_en),
    .pll_rst(pll_rst), .tx_drst(tx_drst), .rx_arst(rx_arst), .rx_drst(rx_drst),
    .lock_ref(lock_ref), .lock_dat(lock_dat), .ready(ready));

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, {pll_rst, tx_drst, rx_arst, rx_drst, lock_ref, lock_dat, ready}, 7'b1111100);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  // R1: reset state
  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
  endtask

  // R2: PLL reset length, other controls held, lock low
  task automatic t_pll_window;
    int n = 0;
    bit held = 1;
    por_n = 1;
    while (pll_rst && n < 10000) begin
      @(negedge clk);
      n++;
      if (pll_rst && !(tx_drst && rx_arst && rx_drst && lock_ref && !lock_dat)) held = 0;
    end
    chk("R2 pll_rst length", n, PLLN);
    chk("R2 controls held during pll reset", held, 1);
  endtask

  // R3: tx waits for lock
  task automatic t_lock_wait;
    repeat (10) @(negedge clk);
    chk("R3 tx_drst held without lock", tx_drst, 1);
    pll_lock = 1;
    @(negedge clk);
    chk("R3 tx_drst released after lock", tx_drst, 0);
  endtask

  // R4: busy then two enabled cycles
  task automatic t_busy_pclk;
    repeat (3) begin
      pclk_en = 1; @(negedge clk);
      pclk_en = 0; @(negedge clk);
    end
    chk("R4 pclk ignored while busy", rx_arst, 1);
    busy = 0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R4 no release without pclk_en", rx_arst, 1);
    pclk_en = 1; @(negedge clk);
    pclk_en = 0; @(negedge clk); @(negedge clk);
    chk("R4 one enabled cycle not enough", rx_arst, 1);
    pclk_en = 1; @(negedge clk);
    pclk_en = 0;
    chk("R4 rx_arst released on second enabled cycle", rx_arst, 0);
  endtask

  // R5: lock-to-reference interval
  task automatic t_ltr;
    int n = 0;
    bit refok = 1;
    while (!lock_dat && n < 10000) begin
      @(negedge clk);
      n++;
      if (!lock_dat && !lock_ref) refok = 0;
    end
    chk("R5 ltr interval", n, LTR);
    chk("R5 lock_ref held then dropped with lock_dat", {refok, lock_ref}, 2'b10);
  endtask

  // R6, R7: lock-to-data interval and ready
  task automatic t_ltd;
    int n = 0;
    while (rx_drst && n < 10000) begin
      @(negedge clk);
      n++;
      if (rx_drst && ready) chk("R7 ready early", ready, 0);
    end
    chk("R6 ltd interval", n, LTD);
    chk("R7 ready with rx_drst release", ready, 1);
    repeat (40) @(negedge clk);
    chk("R7 ready persists", {ready, rx_drst, lock_dat}, 3'b101);
  endtask

  // R8: loss of lock restarts, lock high during pll reset ignored (R2, R3)
  task automatic t_lock_loss;
    int n = 0;
    pll_lock = 0;
    @(negedge clk);
    chk_idle("R8 restart state after lock loss");
    pll_lock = 1;
    while (pll_rst && n < 10000) begin
      @(negedge clk);
      n++;
      if (pll_rst && !tx_drst) chk("R2 lock ignored during pll reset", tx_drst, 1);
    end
    chk("R8 full pll interval on restart", n, PLLN);
    chk("R3 tx still held the cycle pll_rst falls", tx_drst, 1);
    @(negedge clk);
    chk("R3 tx released one cycle later with lock preset", tx_drst, 0);
  endtask

  // R1: asynchronous effect
  task automatic t_async_por;
    @(posedge clk);
    #1 por_n = 0;
    #0.5;
    chk_idle("R1 async reset between edges");
  endtask

  initial begin
    t_reset();
    t_pll_window();
    t_lock_wait();
    t_busy_pclk();
    t_ltr();
    t_ltd();
    t_lock_loss();
    busy = 1;
    t_async_por();
    summary();
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end
endmodule